// File: doc/BRIEF.md
# Wake-Up Muting and Fade-In Sequencer

This block governs when a digital microphone's audio samples become visible after the serial bit clock appears. It runs on a free-running reference clock and watches the incoming bit clock and frame (word-select) line. Bit-clock activity moves it out of its low-power idle state. A long gap in the bit clock puts it back into that state.

On every wake-up it counts bit-clock cycles. It holds the outgoing samples at zero for an initial settling interval and raises a sample-good flag once a longer settling interval has elapsed. When samples are first released it fades them in. A gain index climbs by one per frame until it reaches unity, so that no audible pop occurs. Every going-idle event wipes the counters and the fade state, so the next wake-up repeats the whole sequence. Filtering and serialization sit outside this block.

Top module: `mic_wake_seq`

## Requirements
- R1: `idle_o` is 1 out of reset. It falls after the first bit-clock rising edge, and it rises again once IDLE_LIMIT reference clocks pass with no bit-clock rising edge.
- R2: While fewer than MUTE_CYCLES bit-clock rising edges have been seen since wake-up, `pcm_o` is zero for any input.
- R3: `good_o` is 0 until VALID_CYCLES bit-clock rising edges have been seen since wake-up, and 1 from then on while awake.
- R4: A wake-up after an idle period repeats the muting, fade-in and sample-good sequence from its start.
- R5: The gain index starts at 0 when samples are released. It rises by one on each word-select rising edge seen after release and stops at RAMP_FRAMES.
- R6: `pcm_o` equals (pcm_i × index) arithmetically shifted right by log2(RAMP_FRAMES). Both are treated as signed 24-bit two's complement. At full gain the input passes unchanged, including 0x800000 and 0x7FFFFF.
- R7: The bit-clock cycle count stops at VALID_CYCLES, so `good_o` stays 1 through arbitrarily long awake periods without wrapping.
- R8: While idle, `pcm_o` is zero and `good_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous to clk |
| lrclk_i | input | 1 | Frame (word-select) line, asynchronous to clk |
| pcm_i | input | 24 | Raw signed sample |
| pcm_o | output | 24 | Muted or faded sample, registered |
| good_o | output | 1 | Sample-good flag, registered |
| idle_o | output | 1 | Idle (standby) indicator |

## Verification
Several properties are checked on every clock cycle. Going idle clears the cycle count, and the count holds once saturated. The gain index moves by at most one step and never exceeds its ceiling. The output is zero in the cycle after any muted cycle, and a bit-clock edge always ends the idle state. Other behaviours need a whole scenario to show. These are the exact fade-in values frame by frame, the threshold crossings of the flag, a complete restart after the bit clock stops, and the flag holding through a run longer than the counter's wrap length.

// File: rtl/mws_pkg.sv
package mws_pkg;
  localparam int PCM_W = 24;
  function automatic int cnt_w(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/mws_edge_sync.sv
module mws_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/mws_idle_watch.sv
module mws_idle_watch #(
  parameter int IDLE_LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_rise,
  output logic idle
);
  import mws_pkg::*;
  localparam int CW = cnt_w(IDLE_LIMIT);
  logic [CW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      idle <= 1'b1;
    end else if (bclk_rise) begin
      gap  <= '0;
      idle <= 1'b0;
    end else if (gap == CW'(IDLE_LIMIT)) begin
      idle <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  a_r1_wake_on_edge: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |=> !idle);
  a_r1_sleep_on_gap: assert property (@(posedge clk) disable iff (rst)
    (!bclk_rise && gap == CW'(IDLE_LIMIT)) |=> idle);
endmodule

// File: rtl/mws_wake_counter.sv
module mws_wake_counter #(
  parameter int MUTE_CYCLES  = 4462,
  parameter int VALID_CYCLES = 262144
) (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic bclk_rise,
  output logic released,
  output logic settled
);
  import mws_pkg::*;
  localparam int CW = cnt_w(VALID_CYCLES);
  logic [CW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst || idle)
      ticks <= '0;
    else if (bclk_rise && ticks != CW'(VALID_CYCLES))
      ticks <= ticks + 1'b1;
  end

  assign released = (ticks >= CW'(MUTE_CYCLES));
  assign settled  = (ticks == CW'(VALID_CYCLES));

  a_r4_idle_clears: assert property (@(posedge clk) disable iff (rst)
    idle |=> ticks == '0);
  a_r7_saturates: assert property (@(posedge clk) disable iff (rst)
    (!idle && ticks == CW'(VALID_CYCLES)) |=> (ticks == CW'(VALID_CYCLES) || $past(idle) || idle || ticks == '0));
endmodule

// File: rtl/mws_gain_ramp.sv
module mws_gain_ramp #(
  parameter int W           = 24,
  parameter int RAMP_FRAMES = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         idle,
  input  logic         released,
  input  logic         frame_rise,
  input  logic [W-1:0] pcm,
  output logic [W-1:0] scaled
);
  localparam int SH = $clog2(RAMP_FRAMES);
  localparam int IW = SH + 1;
  localparam int PW = W + IW + 1;

  logic [IW-1:0]        gain;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  always_ff @(posedge clk) begin
    if (rst || idle || !released)
      gain <= '0;
    else if (frame_rise && gain != IW'(RAMP_FRAMES))
      gain <= gain + 1'b1;
  end

  always_comb begin
    prod    = PW'($signed(pcm)) * $signed({1'b0, gain});
    shifted = prod >>> SH;
    scaled  = shifted[W-1:0];
  end

  a_r5_bounded: assert property (@(posedge clk) disable iff (rst)
    gain <= IW'(RAMP_FRAMES));
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gain == $past(gain) || gain == $past(gain) + 1'b1 || gain == '0));
endmodule

// File: rtl/mic_wake_seq.sv
module mic_wake_seq #(
  parameter int IDLE_LIMIT   = 100000,
  parameter int MUTE_CYCLES  = 4462,
  parameter int VALID_CYCLES = 262144,
  parameter int RAMP_FRAMES  = 256,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bclk_i,
  input  logic        lrclk_i,
  input  logic [23:0] pcm_i,
  output logic [23:0] pcm_o,
  output logic        good_o,
  output logic        idle_o
);
  import mws_pkg::*;

  logic bclk_rise, frame_rise, idle, released, settled;
  logic [PCM_W-1:0] scaled;

  mws_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk(clk), .rst(rst), .din(bclk_i), .rise(bclk_rise));
  mws_edge_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
    .clk(clk), .rst(rst), .din(lrclk_i), .rise(frame_rise));

  mws_idle_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst(rst), .bclk_rise(bclk_rise), .idle(idle));

  mws_wake_counter #(.MUTE_CYCLES(MUTE_CYCLES), .VALID_CYCLES(VALID_CYCLES)) u_count (
    .clk(clk), .rst(rst), .idle(idle), .bclk_rise(bclk_rise),
    .released(released), .settled(settled));

  mws_gain_ramp #(.W(PCM_W), .RAMP_FRAMES(RAMP_FRAMES)) u_ramp (
    .clk(clk), .rst(rst), .idle(idle), .released(released),
    .frame_rise(frame_rise), .pcm(pcm_i), .scaled(scaled));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_o  <= '0;
      good_o <= 1'b0;
    end else begin
      pcm_o  <= (released && !idle) ? scaled : '0;
      good_o <= settled && !idle;
    end
  end

  assign idle_o = idle;

  a_r2_muted_zero: assert property (@(posedge clk) disable iff (rst)
    !released |=> pcm_o == '0);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    idle |=> (pcm_o == '0 && !good_o));
  a_r3_good_after_release: assert property (@(posedge clk) disable iff (rst)
    good_o |-> $past(released));
endmodule

// File: tb/mic_wake_seq_tb.sv
module mic_wake_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE  = 20;
  localparam int MUTE  = 40;
  localparam int VALID = 600;
  localparam int RAMP  = 16;
  localparam int SH    = 4;

  logic clk = 0, rst = 1, bclk = 0, lrclk = 0;
  logic [23:0] pcm_in = '0;
  logic [23:0] pcm_out;
  logic good, idle;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mic_wake_seq #(.IDLE_LIMIT(IDLE), .MUTE_CYCLES(MUTE), .VALID_CYCLES(VALID),
                 .RAMP_FRAMES(RAMP)) dut_i (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrclk_i(lrclk), .pcm_i(pcm_in),
    .pcm_o(pcm_out), .good_o(good), .idle_o(idle));

  function automatic logic [23:0] exp_scale(input logic [23:0] s, input int g);
    longint signed v;
    v = longint'($signed(s)) * longint'(g);
    v = v >>> SH;
    return v[23:0];
  endfunction

  function automatic int mag(input logic [23:0] s);
    return s[23] ? -int'($signed(s)) : int'($signed(s));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame of 64 bit clocks; check at position 48 (and 20 in frame 0)
  task automatic frame(input int f, input logic [23:0] s, input bit fixed_in,
                       inout int prev_mag);
    int g;
    bit vexp;
    if (!fixed_in) pcm_in = s;
    for (int p = 0; p < 64; p++) begin
      lrclk = (p >= 32);
      bclk = 0; step(2);
      bclk = 1; step(2);
      if (f == 0 && p == 20) begin
        check(pcm_out == 0, "R2 muted", pcm_out, 0);
        check(!good, "R3 early", good, 0);
        check(!idle, "R1 awake", idle, 0);
      end
      if (p == 48) begin
        g = (f < RAMP) ? f : RAMP;
        check(pcm_out == exp_scale(pcm_in, g), $sformatf("R6 frame %0d", f),
              pcm_out, exp_scale(pcm_in, g));
        vexp = (64*f + 49) > VALID;
        check(good == vexp, $sformatf("R3 R7 flag frame %0d", f), good, vexp);
        if (fixed_in) begin
          check(mag(pcm_out) >= prev_mag, "R5 monotonic", mag(pcm_out), prev_mag);
          prev_mag = mag(pcm_out);
        end
      end
    end
  endtask

  task automatic go_idle();
    bclk = 0; lrclk = 0;
    pcm_in = 24'h123456;
    step(IDLE + 12);
    check(idle, "R1 idle after gap", idle, 1);
    check(pcm_out == 0, "R8 idle zero", pcm_out, 0);
    check(!good, "R8 idle flag", good, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int pm;
    logic [23:0] s;
    void'($urandom(32'd1234));
    step(4);
    rst = 0;
    step(2);
    check(idle, "R1 reset idle", idle, 1);
    check(pcm_out == 0, "R8 reset out", pcm_out, 0);
    check(!good, "R3 reset flag", good, 0);

    // wake 1: random data with directed extremes, long run past wrap length
    pm = 0;
    for (int f = 0; f < 40; f++) begin
      s = 24'($urandom);
      if (f == 18) s = 24'h800000;
      if (f == 19) s = 24'h7FFFFF;
      frame(f, s, 1'b0, pm);
    end
    go_idle();

    // wake 2: constant input, restart repeats whole sequence
    pm = 0;
    pcm_in = 24'hC00001;
    for (int f = 0; f < 20; f++) frame(f, 24'h0, 1'b1, pm);
    check(pcm_out == 24'hC00001, "R6 full gain", pcm_out, 24'hC00001);
    go_idle();

    // wake 3: positive constant, short
    pm = 0;
    pcm_in = 24'h3FFFF0;
    for (int f = 0; f < 6; f++) frame(f, 24'h0, 1'b1, pm);
    check(good == 0, "R4 flag restarted", good, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule